// File: doc/BRIEF.md
# Eight-LED Pattern Sequencer

The sequencer drives a row of eight LEDs through a fixed library of eight display patterns. Each pattern is a short loop of frames. The library covers single-direction shifts, bounces and converging pairs, jumps across the row, a growing bar and an alternating checkerboard. Steps are timed by a beat derived from the system clock. A fast beat advances one frame per base tick, and a slow beat advances one frame every second base tick. With the default parameters, these come to 0.25 s and 0.5 s per step.

Two operating modes are chosen by a single select input. In ordered mode, the patterns play in index order. After each full pass through all eight patterns, the beat flips between fast and slow. In random mode, a free-running 16-bit LFSR picks both the next pattern and its beat. In both modes, a pattern plays a fixed number of complete loops before it hands over. The select input is looked at only at those hand-over points, so a pattern in progress is never cut short.

Top module: `ledPatternSequencer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `led` is 8'h01. This is pattern 0, frame 0, at the fast beat, with all counters cleared.
- R2: A base tick occurs once every TICK_CYCLES = CLK_HZ/BASE_HZ clocks, the first one on the TICK_CYCLES-th rising edge after reset is released. At the fast beat, every base tick is a step.
- R3: At the slow beat, a step occurs on every second base tick, counted from the step that began the pattern. The gap between slow steps is therefore 2*TICK_CYCLES clocks.
- R4: The frames for step s of each pattern are as follows. A frame sets bit 1<<pos (bit 0 is the first LED).
  - Pattern 0: pos = s, length 8.
  - Pattern 1: pos = 7-s, length 8.
  - Pattern 2: pos = s for s<8, otherwise 14-s, length 14.
  - Pattern 3: bits k and 7-k, where k = s for s<4, otherwise 6-s, length 6.
  - Pattern 4: pos = 2s for s<4, otherwise 2(s-4)+1, length 8.
  - Pattern 5: the low s+1 bits are set, length 8.
  - Pattern 6: 8'h55 on even s and 8'hAA on odd s, length 2.
  - Pattern 7: pos = 3s mod 8, length 8.
- R5: After the last frame of a pattern, the step index returns to 0. After REPEATS complete loops (default 2), the pattern hands over to the next one.
- R6: In ordered mode (`randomMode` = 0 at the hand-over edge), the next pattern is the current index plus 1, modulo 8. The beat flips when pattern 7 hands over, and is otherwise kept.
- R7: In random mode, the LFSR is sampled at the hand-over edge. Bits [2:0] give the next pattern, and bit 3 gives the beat (1 = slow). The LFSR starts at 16'hACE1 and advances on every clock as a right-shifting Galois register: when the bit shifted out is 1, the shifted value is XORed with 16'hB400. The LFSR is never zero.
- R8: `randomMode` affects only the choice made at a hand-over edge. Changing it mid-pattern alters neither the frames nor the timing until that pattern hands over.
- R9: `led` is registered. It takes the new frame on the clock edge at which the step occurs, and holds its value on every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| randomMode | input | 1 | 0 = ordered sequence, 1 = pseudo-random sequence |
| led | output | 8 | LED drive, one bit per LED |

## Verification
Two functions can land on the same edge.

The first pair is a pattern hand-over and a change of the mode select. The bench watches its own reference model for the cycle whose next edge is a hand-over, and flips `randomMode` exactly then. The choice made on that edge must already follow the new mode. The bench also flips the select mid-pattern, where the change must have no visible effect until the next hand-over.

The second pair is the hand-over of pattern 7 in ordered mode, which also flips the beat. The bench checks that the following pattern starts with the new step spacing from its very first step. Every frame, on every cycle, is judged against the bench's own model of the requirements.

// File: rtl/ledSeqPkg.sv
package ledSeqPkg;

  typedef struct packed {
    logic       step;     // advance one frame this cycle
    logic       load;     // hand over to nextPat this cycle
    logic [2:0] nextPat;  // pattern chosen for the hand-over
  } seqStrobe_t;

  function automatic logic [3:0] patLen(input logic [2:0] p);
    case (p)
      3'd2:    patLen = 4'd14;
      3'd3:    patLen = 4'd6;
      3'd6:    patLen = 4'd2;
      default: patLen = 4'd8;
    endcase
  endfunction

  function automatic logic [7:0] patFrame(input logic [2:0] p, input logic [3:0] s);
    logic [3:0] t;
    logic [2:0] pos;
    t   = 4'd0;
    pos = s[2:0];
    case (p)
      3'd0: patFrame = 8'h01 << pos;
      3'd1: patFrame = 8'h80 >> pos;
      3'd2: begin
        t = (s < 4'd8) ? s : (4'd14 - s);
        patFrame = 8'h01 << t[2:0];
      end
      3'd3: begin
        t = (s < 4'd4) ? s : (4'd6 - s);
        patFrame = (8'h01 << t[2:0]) | (8'h80 >> t[2:0]);
      end
      3'd4: patFrame = 8'h01 << {s[1:0], s[2]};
      3'd5: patFrame = 8'hFF >> (3'd7 - pos);
      3'd6: patFrame = s[0] ? 8'hAA : 8'h55;
      default: begin
        t = {s[2:0], 1'b0} + {1'b0, s[2:0]};
        patFrame = 8'h01 << t[2:0];
      end
    endcase
  endfunction

endpackage

// File: rtl/ledSeqCtrl.sv
module ledSeqCtrl
  import ledSeqPkg::*;
#(
  parameter int TICK_CYCLES = 4,
  parameter int REPEATS     = 2,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       randomMode,
  input  logic       lastStep,
  input  logic [2:0] patIdx,
  output seqStrobe_t strobe
);
  localparam int CNT_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int REP_W = (REPEATS > 1) ? $clog2(REPEATS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_CYCLES - 1);
  localparam logic [REP_W-1:0] REP_LAST = REP_W'(REPEATS - 1);

  logic [CNT_W-1:0] baseCnt;
  logic             baseTick;
  logic             slowPhase;
  logic             beatSlow;
  logic [REP_W-1:0] repCnt;
  logic [15:0]      lfsrQ;
  logic             stepTick;
  logic             handOver;

  // base tick generator
  assign baseTick = (baseCnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) baseCnt <= '0;
    else     baseCnt <= baseTick ? '0 : baseCnt + 1'b1;
  end

  // slow beat steps on every second base tick
  assign stepTick = baseTick && (!beatSlow || slowPhase);

  always_ff @(posedge clk) begin
    if (rst)           slowPhase <= 1'b0;
    else if (stepTick) slowPhase <= 1'b0;
    else if (baseTick) slowPhase <= ~slowPhase;
  end

  // free-running Galois LFSR
  always_ff @(posedge clk) begin
    if (rst) lfsrQ <= LFSR_SEED;
    else     lfsrQ <= lfsrQ[0] ? ((lfsrQ >> 1) ^ 16'hB400) : (lfsrQ >> 1);
  end

  // loop counter and hand-over decision
  assign handOver = stepTick && lastStep && (repCnt == REP_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      repCnt   <= '0;
      beatSlow <= 1'b0;
    end else if (stepTick && lastStep) begin
      if (handOver) begin
        repCnt <= '0;
        if (randomMode)           beatSlow <= lfsrQ[3];
        else if (patIdx == 3'd7)  beatSlow <= ~beatSlow;
      end else begin
        repCnt <= repCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.step    = stepTick;
    strobe.load    = handOver;
    strobe.nextPat = randomMode ? lfsrQ[2:0] : patIdx + 3'd1;
  end

  a_r7_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
    lfsrQ != 16'h0);

  a_r8_beat_only_at_handover: assert property (@(posedge clk) disable iff (rst)
    !handOver |=> $stable(beatSlow));

  a_r3_slow_gap: assert property (@(posedge clk) disable iff (rst)
    (stepTick && beatSlow) |=> !stepTick);

  a_r2_step_on_tick: assert property (@(posedge clk) disable iff (rst)
    stepTick |=> (baseCnt == '0));

endmodule

// File: rtl/ledSeqDatapath.sv
module ledSeqDatapath
  import ledSeqPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seqStrobe_t strobe,
  output logic       lastStep,
  output logic [2:0] patIdx,
  output logic [7:0] led
);
  logic [3:0] stepIdx;
  logic [2:0] patNext;
  logic [3:0] stepNext;

  assign lastStep = (stepIdx == patLen(patIdx) - 4'd1);

  always_comb begin
    patNext  = patIdx;
    stepNext = stepIdx;
    if (strobe.step) begin
      if (strobe.load) begin
        patNext  = strobe.nextPat;
        stepNext = 4'd0;
      end else if (lastStep) begin
        stepNext = 4'd0;
      end else begin
        stepNext = stepIdx + 4'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      patIdx  <= 3'd0;
      stepIdx <= 4'd0;
      led     <= 8'h01;
    end else begin
      patIdx  <= patNext;
      stepIdx <= stepNext;
      led     <= patFrame(patNext, stepNext);
    end
  end

  a_r5_step_in_range: assert property (@(posedge clk) disable iff (rst)
    stepIdx < patLen(patIdx));

  a_r9_led_holds: assert property (@(posedge clk) disable iff (rst)
    !strobe.step |=> $stable(led));

  a_r6_pattern_holds: assert property (@(posedge clk) disable iff (rst)
    !strobe.load |=> $stable(patIdx));

endmodule

// File: rtl/ledPatternSequencer.sv
module ledPatternSequencer
  import ledSeqPkg::*;
#(
  parameter int CLK_HZ  = 100_000_000,
  parameter int BASE_HZ = 4,
  parameter int REPEATS = 2,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       randomMode,
  output logic [7:0] led
);
  localparam int TICK_CYCLES = CLK_HZ / BASE_HZ;

  seqStrobe_t strobe;
  logic       lastStep;
  logic [2:0] patIdx;

  ledSeqCtrl #(
    .TICK_CYCLES(TICK_CYCLES),
    .REPEATS    (REPEATS),
    .LFSR_SEED  (LFSR_SEED)
  ) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .randomMode(randomMode),
    .lastStep  (lastStep),
    .patIdx    (patIdx),
    .strobe    (strobe)
  );

  ledSeqDatapath i_data (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .lastStep(lastStep),
    .patIdx  (patIdx),
    .led     (led)
  );

endmodule

// File: tb/test_ledPatternSequencer.sv
module test_ledPatternSequencer;
  localparam int TICK = 4;
  localparam int REPS = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       randomMode = 1'b0;
  logic [7:0] led;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  ledPatternSequencer #(
    .CLK_HZ (TICK * 4),
    .BASE_HZ(4),
    .REPEATS(REPS)
  ) i_ledPatternSequencer (
    .clk       (clk),
    .rst       (rst),
    .randomMode(randomMode),
    .led       (led)
  );

  // reference model built from the requirements
  function automatic int refLen(input int p);
    case (p)
      2: return 14;
      3: return 6;
      6: return 2;
      default: return 8;
    endcase
  endfunction

  function automatic logic [7:0] refFrame(input int p, input int s);
    logic [7:0] f;
    int k;
    f = 8'h00;
    case (p)
      0: f[s] = 1'b1;
      1: f[7-s] = 1'b1;
      2: begin
        k = (s < 8) ? s : 14 - s;
        f[k] = 1'b1;
      end
      3: begin
        k = (s < 4) ? s : 6 - s;
        f[k] = 1'b1;
        f[7-k] = 1'b1;
      end
      4: f[(s < 4) ? 2*s : 2*(s-4)+1] = 1'b1;
      5: for (int i = 0; i <= s; i++) f[i] = 1'b1;
      6: f = (s % 2 == 0) ? 8'h55 : 8'hAA;
      default: f[(3*s) % 8] = 1'b1;
    endcase
    return f;
  endfunction

  int          mCnt, mPat, mStep, mRep;
  logic        mPhase, mSlow;
  logic [15:0] mLfsr;
  logic        mTick, mStepT, mHand;

  assign mTick  = (mCnt == TICK - 1);
  assign mStepT = mTick && (!mSlow || mPhase);
  assign mHand  = mStepT && (mStep == refLen(mPat) - 1) && (mRep == REPS - 1);

  always @(posedge clk) begin
    if (rst) begin
      mCnt <= 0; mPat <= 0; mStep <= 0; mRep <= 0;
      mPhase <= 1'b0; mSlow <= 1'b0; mLfsr <= 16'hACE1;
    end else begin
      mLfsr <= mLfsr[0] ? ((mLfsr >> 1) ^ 16'hB400) : (mLfsr >> 1);
      mCnt  <= mTick ? 0 : mCnt + 1;
      mPhase <= mStepT ? 1'b0 : (mTick ? ~mPhase : mPhase);
      if (mStepT) begin
        if (mStep == refLen(mPat) - 1) begin
          mStep <= 0;
          if (mRep == REPS - 1) begin
            mRep <= 0;
            if (randomMode) begin
              mPat  <= int'(mLfsr[2:0]);
              mSlow <= mLfsr[3];
            end else begin
              mPat <= (mPat + 1) % 8;
              if (mPat == 7) mSlow <= ~mSlow;
            end
          end else mRep <= mRep + 1;
        end else mStep <= mStep + 1;
      end
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: led=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic runCompare(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(req, led, refFrame(mPat, mStep));
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 in reset", led, 8'h01);
    rst = 1'b0;
  endtask

  // R1, R2: reset frame and first step timing
  task automatic testFirstStep();
    doReset();
    repeat (TICK - 1) @(posedge clk);
    @(negedge clk);
    check("R1 held before first tick", led, 8'h01);
    @(posedge clk);
    @(negedge clk);
    check("R2 first step at tick", led, 8'h02);
    repeat (TICK - 1) @(negedge clk);
    check("R2 fast beat holds", led, 8'h02);
    @(negedge clk);
    check("R2 second fast step", led, 8'h04);
  endtask

  // R4, R5, R6, R3: two ordered rounds, fast then slow
  task automatic testOrdered();
    randomMode = 1'b0;
    doReset();
    runCompare("R4 R5 R6 ordered fast round", 124 * TICK);
    runCompare("R3 R6 ordered slow round", 124 * 2 * TICK);
    runCompare("R6 beat flips back to fast", 20 * TICK);
  endtask

  // R3: explicit slow step spacing on pattern 0 after first round
  task automatic testSlowGap();
    randomMode = 1'b0;
    doReset();
    repeat (124 * TICK) @(negedge clk);
    check("R3 slow round starts at pattern 0", led, 8'h01);
    repeat (2 * TICK - 1) @(negedge clk);
    check("R3 slow beat holds one base tick later", led, 8'h01);
    @(negedge clk);
    check("R3 slow step after two base ticks", led, 8'h02);
  endtask

  // R7: random mode choices
  task automatic testRandom();
    randomMode = 1'b1;
    doReset();
    runCompare("R7 random sequence", 3000);
  endtask

  // R8: mode change mid-pattern and exactly at the hand-over edge
  task automatic testModeSwitch();
    randomMode = 1'b0;
    doReset();
    repeat (5 * TICK) @(negedge clk);
    randomMode = 1'b1;
    runCompare("R8 mid-pattern switch to random", 400);
    @(negedge clk);
    while (!mHand) @(negedge clk);
    randomMode = 1'b0;
    runCompare("R8 switch on hand-over edge", 300);
    @(negedge clk);
    while (!mHand) @(negedge clk);
    randomMode = 1'b1;
    runCompare("R8 R7 switch to random on hand-over edge", 300);
    randomMode = 1'b0;
    runCompare("R8 ordered after random", 600);
  endtask

  // R9: output holds between steps
  task automatic testHold();
    logic [7:0] prev;
    randomMode = 1'b0;
    doReset();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      prev = led;
      if (!mStepT) begin
        @(negedge clk);
        check("R9 led holds without step", led, prev);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    testFirstStep();
    testOrdered();
    testSlowGap();
    testRandom();
    testModeSwitch();
    testHold();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule